// File: doc/BRIEF.md
# Charge Command Watchdog Register Block

This block holds the host-visible control state of a battery charger controller: a 16-bit option word, a charge-current command and a charge-voltage command. All three sit on a plain synchronous register interface: address, write data, write enable, and a read data path that is a function of the address alone. The command values and the option word are also driven out as ports so that the charger core can use them directly.

A watchdog guards the two command registers. When the host stops refreshing them for longer than the period picked by a 2-bit field in the option word, the block zeroes the current command and raises an expired flag. Time is measured in ticks from an internal prescaler, so a simulation can run with short periods. A second rule clears the input-current-limit enable bit when a synchronized battery-present input falls, provided the auto-disable option is set. The host may set that bit again afterwards.

Top module: `chg_cmd_wdog`

## Requirements
- R1: After reset the option word reads 16'hE202, both command registers read 0 and the expired flag is low.
- R2: Address 0 is the option word, address 1 the current command and address 2 the voltage command. All 16 bits of each can be written and read back. Address 3 reads 0, and a write to it changes nothing.
- R3: The timeout select field is option bits 14:13, with 00 = off, 01 = short, 10 = mid, 11 = long (T_SHORT, T_MID, T_LONG ticks). Let E be the clock edge of the last restart and L the selected tick count. The expired flag rises at edge E + L*PRESCALE and no earlier.
- R4: At expiry the current command becomes 0. The voltage command keeps its value.
- R5: A write to the current or the voltage command register restarts the count and clears the expired flag at that edge.
- R6: While the select field is 00 the count is held at zero and no expiry occurs. Both commands keep their values however long the wait.
- R7: A write to the option word restarts the count when it changes the select field or when the flag is expired.
- R8: When a current command write lands on the same edge as a timeout, the written value is kept and the flag stays low.
- R9: When option bit 12 is 1, a falling edge on bat_present_i clears option bit 1 three clock edges after the input changes. The other option bits are unchanged.
- R10: When option bit 12 is 0, a falling bat_present_i leaves option bit 1 unchanged.
- R11: After an automatic clear, a host write of 1 to option bit 1 sets it again, and it stays set while bat_present_i remains low.
- R12: Once raised, the expired flag and the zeroed current command hold until a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Write data |
| we_i | input | 1 | Write enable, one cycle per write |
| rdata_o | output | 16 | Read data for addr_i |
| bat_present_i | input | 1 | Asynchronous battery-present level |
| chg_current_o | output | 16 | Current command register |
| chg_voltage_o | output | 16 | Voltage command register |
| option_o | output | 16 | Option word |
| wd_expired_o | output | 1 | Watchdog expired flag |

## Verification
The hardest case to reach is a command write that lands on exactly the same edge as the timeout, because that edge sits L*PRESCALE cycles after a restart whose phase the bench must know. The prescaler is cleared on every restart, so the bench can count cycles from its own write and place a second write on the expiry edge for each select code. The bench sweeps all three nonzero select codes with small tick counts. For each code it checks the flag one cycle before and at the expiry edge, then restarts the timer from the option word and from the voltage register and checks the flag again.

// File: rtl/chg_pkg.sv
package chg_pkg;

    localparam int REG_W = 16;

    typedef enum logic [1:0] {
        WD_OFF   = 2'b00,
        WD_SHORT = 2'b01,
        WD_MID   = 2'b10,
        WD_LONG  = 2'b11
    } wd_sel_e;

    localparam logic [1:0] ADDR_OPT  = 2'd0;
    localparam logic [1:0] ADDR_ICHG = 2'd1;
    localparam logic [1:0] ADDR_VCHG = 2'd2;

    localparam int OPT_SEL_LO  = 13;
    localparam int OPT_SEL_HI  = 14;
    localparam int OPT_AUTODIS = 12;
    localparam int OPT_ILIM_EN = 1;

    localparam logic [REG_W-1:0] OPT_RESET  = 16'hE202;
    localparam logic [REG_W-1:0] ICHG_RESET = '0;
    localparam logic [REG_W-1:0] VCHG_RESET = '0;

    typedef struct packed {
        logic [REG_W-1:0] opt;
        logic [REG_W-1:0] ichg;
        logic [REG_W-1:0] vchg;
    } regs_t;

endpackage

// File: rtl/chg_tick_gen.sv
module chg_tick_gen #(
    parameter int PRESCALE = 1000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    output logic tick_o
);

    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    generate
        if (PRESCALE <= 1) begin : g_pass
            assign tick_o = ~clear_i;
        end else begin : g_div
            localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

            logic [PW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (clear_i) begin
                    cnt_d = '0;
                end else if (cnt_q == LAST) begin
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_d;
                end
            end

            assign tick_o = (cnt_q == LAST);

            AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
                tick_o |=> !tick_o); // R3

            AST_TICK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
                clear_i |=> !tick_o); // R3
        end
    endgenerate

endmodule

// File: rtl/chg_bat_edge.sv
module chg_bat_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic bat_i,
    output logic fall_o
);

    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } edge_t;

    edge_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = bat_i;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fall_o = st_q.prev & ~st_q.sync;

    AST_FALL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |=> !fall_o); // R11

endmodule

// File: rtl/chg_wdog.sv
module chg_wdog
    import chg_pkg::*;
#(
    parameter int T_SHORT = 5,
    parameter int T_MID   = 88,
    parameter int T_LONG  = 175
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] sel_i,
    input  logic       tick_i,
    input  logic       restart_i,
    output logic       hold_o,
    output logic       expire_pulse_o,
    output logic       expired_o
);

    localparam int TMAX = (T_LONG > T_MID) ? ((T_LONG > T_SHORT) ? T_LONG : T_SHORT)
                                           : ((T_MID > T_SHORT) ? T_MID : T_SHORT);
    localparam int CW = $clog2(TMAX + 1);
    localparam logic [CW-1:0] LIM_S = CW'(T_SHORT);
    localparam logic [CW-1:0] LIM_M = CW'(T_MID);
    localparam logic [CW-1:0] LIM_L = CW'(T_LONG);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          expired;
    } wd_t;

    wd_t           wd_d, wd_q;
    logic [CW-1:0] lim;
    logic [CW-1:0] lim_m1;
    logic          pulse;

    always_comb begin
        case (wd_sel_e'(sel_i))
            WD_SHORT: lim = LIM_S;
            WD_MID:   lim = LIM_M;
            default:  lim = LIM_L;
        endcase
        lim_m1 = lim - 1'b1;
    end

    always_comb begin
        wd_d  = wd_q;
        pulse = 1'b0;
        if (restart_i) begin
            wd_d.cnt     = '0;
            wd_d.expired = 1'b0;
        end else if (wd_sel_e'(sel_i) == WD_OFF) begin
            wd_d.cnt = '0;
        end else if (!wd_q.expired && tick_i) begin
            if (wd_q.cnt >= lim_m1) begin
                wd_d.cnt     = '0;
                wd_d.expired = 1'b1;
                pulse        = 1'b1;
            end else begin
                wd_d.cnt = wd_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wd_q <= '0;
        end else begin
            wd_q <= wd_d;
        end
    end

    assign expired_o      = wd_q.expired;
    assign expire_pulse_o = pulse;
    assign hold_o         = (wd_sel_e'(sel_i) == WD_OFF) | wd_q.expired;

    AST_NO_EXPIRE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i == 2'b00) |-> !wd_q.expired); // R6

    AST_EXPIRED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wd_q.expired && !restart_i) |=> wd_q.expired); // R12

    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i != 2'b00) |-> (wd_q.cnt < lim)); // R3

    AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> (!wd_q.expired && wd_q.cnt == '0)); // R5

endmodule

// File: rtl/chg_cmd_wdog.sv
module chg_cmd_wdog
    import chg_pkg::*;
#(
    parameter int PRESCALE = 1000000,
    parameter int T_SHORT  = 5,
    parameter int T_MID    = 88,
    parameter int T_LONG   = 175
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [1:0]  addr_i,
    input  logic [15:0] wdata_i,
    input  logic        we_i,
    output logic [15:0] rdata_o,
    input  logic        bat_present_i,
    output logic [15:0] chg_current_o,
    output logic [15:0] chg_voltage_o,
    output logic [15:0] option_o,
    output logic        wd_expired_o
);

    regs_t rg_d, rg_q;

    logic wr_opt, wr_ichg, wr_vchg;
    logic sel_change, restart;
    logic hold, tick, expire_pulse, expired;
    logic bat_fall;

    assign wr_opt  = we_i && (addr_i == ADDR_OPT);
    assign wr_ichg = we_i && (addr_i == ADDR_ICHG);
    assign wr_vchg = we_i && (addr_i == ADDR_VCHG);

    assign sel_change = wdata_i[OPT_SEL_HI:OPT_SEL_LO] != rg_q.opt[OPT_SEL_HI:OPT_SEL_LO];
    assign restart    = wr_ichg | wr_vchg | (wr_opt & (expired | sel_change));

    chg_tick_gen #(
        .PRESCALE (PRESCALE)
    ) u_tick (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (restart | hold),
        .tick_o  (tick)
    );

    chg_wdog #(
        .T_SHORT (T_SHORT),
        .T_MID   (T_MID),
        .T_LONG  (T_LONG)
    ) u_wdog (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .sel_i          (rg_q.opt[OPT_SEL_HI:OPT_SEL_LO]),
        .tick_i         (tick),
        .restart_i      (restart),
        .hold_o         (hold),
        .expire_pulse_o (expire_pulse),
        .expired_o      (expired)
    );

    chg_bat_edge u_bat (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .bat_i  (bat_present_i),
        .fall_o (bat_fall)
    );

    always_comb begin
        rg_d = rg_q;
        if (wr_opt) begin
            rg_d.opt = wdata_i;
        end else if (bat_fall && rg_q.opt[OPT_AUTODIS]) begin
            rg_d.opt[OPT_ILIM_EN] = 1'b0;
        end
        if (wr_ichg) begin
            rg_d.ichg = wdata_i;
        end else if (expire_pulse) begin
            rg_d.ichg = '0;
        end
        if (wr_vchg) begin
            rg_d.vchg = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rg_q.opt  <= OPT_RESET;
            rg_q.ichg <= ICHG_RESET;
            rg_q.vchg <= VCHG_RESET;
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        case (addr_i)
            ADDR_OPT:  rdata_o = rg_q.opt;
            ADDR_ICHG: rdata_o = rg_q.ichg;
            ADDR_VCHG: rdata_o = rg_q.vchg;
            default:   rdata_o = '0;
        endcase
    end

    assign chg_current_o = rg_q.ichg;
    assign chg_voltage_o = rg_q.vchg;
    assign option_o      = rg_q.opt;
    assign wd_expired_o  = expired;

    AST_EXPIRE_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (expire_pulse && !wr_ichg) |=> (rg_q.ichg == '0)); // R4

    AST_EXPIRE_KEEPS_V: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (expire_pulse && !wr_vchg) |=> $stable(rg_q.vchg)); // R4

    AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_ichg |=> (rg_q.ichg == $past(wdata_i) && !expired)); // R8

    AST_AUTO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bat_fall && rg_q.opt[OPT_AUTODIS] && !wr_opt) |=> !rg_q.opt[OPT_ILIM_EN]); // R9

    AST_OPT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_opt && !(bat_fall && rg_q.opt[OPT_AUTODIS])) |=> $stable(rg_q.opt)); // R10

    AST_OPT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_opt && expired) |=> !expired); // R7

endmodule

// File: tb/sim_chg_cmd_wdog.sv
`timescale 1ns/1ps
module sim_chg_cmd_wdog;

    localparam int P  = 3;
    localparam int TS = 4;
    localparam int TM = 7;
    localparam int TL = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  addr;
    logic [15:0] wdata;
    logic        we;
    logic [15:0] rdata;
    logic        bat;
    logic [15:0] ichg, vchg, opt;
    logic        expd;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    chg_cmd_wdog #(
        .PRESCALE (P),
        .T_SHORT  (TS),
        .T_MID    (TM),
        .T_LONG   (TL)
    ) u0 (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .addr_i        (addr),
        .wdata_i       (wdata),
        .we_i          (we),
        .rdata_o       (rdata),
        .bat_present_i (bat),
        .chg_current_o (ichg),
        .chg_voltage_o (vchg),
        .option_o      (opt),
        .wd_expired_o  (expd)
    );

    function automatic logic [15:0] optv(input logic [1:0] s, input logic b12, input logic b1);
        return {1'b1, s, b12, 1'b0, 1'b0, 1'b1, 1'b0, 6'b0, b1, 1'b0};
    endfunction

    function automatic int ticks_for(input int s);
        return (s == 1) ? TS : (s == 2) ? TM : TL;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic waitn(input int k);
        repeat (k) @(negedge clk);
    endtask

    // called at a negedge; the write is taken at the next posedge
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        addr  = a;
        wdata = d;
        we    = 1'b1;
        @(negedge clk);
        we    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] r;
        logic [15:0] sv0, sv1, sv2;
        rst_n = 1'b0;
        we    = 1'b0;
        addr  = 2'd0;
        wdata = '0;
        bat   = 1'b1;
        waitn(3);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, r); chk("R1 option", r, 16'hE202);
        rd(2'd1, r); chk("R1 current", r, 16'h0000);
        rd(2'd2, r); chk("R1 voltage", r, 16'h0000);
        chk("R1 expired", {15'b0, expd}, 16'h0);

        wr(2'd0, optv(2'b00, 1'b0, 1'b1));

        // R2 read/write sweep, select field kept at 00
        for (int i = 0; i < 8; i++) begin
            logic [15:0] p;
            p = (16'h1357 * 16'(i + 1)) ^ 16'(i << 9);
            wr(2'd1, p);         rd(2'd1, r); chk("R2 current rw", r, p);
            wr(2'd2, ~p);        rd(2'd2, r); chk("R2 voltage rw", r, ~p);
            wr(2'd0, p & 16'h9FFF); rd(2'd0, r); chk("R2 option rw", r, p & 16'h9FFF);
        end
        wr(2'd0, optv(2'b00, 1'b0, 1'b1));
        rd(2'd0, sv0); rd(2'd1, sv1); rd(2'd2, sv2);
        wr(2'd3, 16'hFFFF);
        rd(2'd3, r); chk("R2 addr3 reads zero", r, 16'h0000);
        rd(2'd0, r); chk("R2 addr3 write no effect opt", r, sv0);
        rd(2'd1, r); chk("R2 addr3 write no effect cur", r, sv1);
        rd(2'd2, r); chk("R2 addr3 write no effect volt", r, sv2);

        // R6 disabled watchdog
        wr(2'd1, 16'h00A5);
        wr(2'd2, 16'h0C0C);
        waitn(4 * TL * P);
        chk("R6 no expiry when off", {15'b0, expd}, 16'h0);
        chk("R6 current kept", ichg, 16'h00A5);
        chk("R6 voltage kept", vchg, 16'h0C0C);

        // R3 R4 R12 R7 R5 for every nonzero select code
        for (int s = 1; s <= 3; s++) begin
            int lc;
            lc = ticks_for(s) * P;
            wr(2'd0, optv(2'(s), 1'b0, 1'b1));
            wr(2'd1, 16'h0100 + 16'(s));
            waitn(lc - 1);
            chk("R3 not yet expired", {15'b0, expd}, 16'h0);
            chk("R3 current before expiry", ichg, 16'h0100 + 16'(s));
            waitn(1);
            chk("R3 expired on time", {15'b0, expd}, 16'h1);
            chk("R4 current zeroed", ichg, 16'h0000);
            chk("R4 voltage kept", vchg, 16'h0C0C);
            waitn(15);
            chk("R12 flag held", {15'b0, expd}, 16'h1);
            chk("R12 current held zero", ichg, 16'h0000);
            wr(2'd0, optv(2'(s), 1'b0, 1'b1));
            chk("R7 option write clears flag", {15'b0, expd}, 16'h0);
            waitn(lc - 1);
            chk("R7 restart timing before", {15'b0, expd}, 16'h0);
            waitn(1);
            chk("R7 restart timing at", {15'b0, expd}, 16'h1);
            wr(2'd2, 16'h0C0C);
            chk("R5 voltage write clears flag", {15'b0, expd}, 16'h0);
            chk("R5 current stays zero", ichg, 16'h0000);
            waitn(lc - 1);
            chk("R5 restart timing before", {15'b0, expd}, 16'h0);
            waitn(1);
            chk("R5 restart timing at", {15'b0, expd}, 16'h1);
        end

        // R8 write on the timeout edge, short code
        wr(2'd0, optv(2'b01, 1'b0, 1'b1));
        wr(2'd1, 16'h0055);
        waitn(TS * P - 1);
        wr(2'd1, 16'h0077);
        chk("R8 write wins flag", {15'b0, expd}, 16'h0);
        chk("R8 write wins value", ichg, 16'h0077);
        waitn(TS * P - 1);
        chk("R8 restarted before", {15'b0, expd}, 16'h0);
        waitn(1);
        chk("R8 restarted at", {15'b0, expd}, 16'h1);

        // R7 select change while running
        wr(2'd0, optv(2'b01, 1'b0, 1'b1));
        wr(2'd1, 16'h0033);
        waitn(5);
        wr(2'd0, optv(2'b11, 1'b0, 1'b1));
        waitn(TL * P - 1);
        chk("R7 sel change restart before", {15'b0, expd}, 16'h0);
        waitn(1);
        chk("R7 sel change restart at", {15'b0, expd}, 16'h1);
        wr(2'd0, optv(2'b00, 1'b0, 1'b1));
        chk("R7 write to off clears flag", {15'b0, expd}, 16'h0);

        // R10 auto-disable off
        bat = 1'b0;
        waitn(6);
        rd(2'd0, r); chk("R10 bit1 unchanged", r, optv(2'b00, 1'b0, 1'b1));
        bat = 1'b1;
        waitn(5);

        // R9 auto clear timing
        wr(2'd0, optv(2'b00, 1'b1, 1'b1));
        bat = 1'b0;
        waitn(2);
        chk("R9 bit1 before clear", opt, optv(2'b00, 1'b1, 1'b1));
        waitn(1);
        chk("R9 bit1 cleared, rest kept", opt, optv(2'b00, 1'b1, 1'b0));

        // R11 host re-enable while input low
        wr(2'd0, optv(2'b00, 1'b1, 1'b1));
        waitn(8);
        rd(2'd0, r); chk("R11 bit1 set again", r, optv(2'b00, 1'b1, 1'b1));

        // R9 second falling edge clears again
        bat = 1'b1;
        waitn(5);
        bat = 1'b0;
        waitn(3);
        chk("R9 second fall clears", opt, optv(2'b00, 1'b1, 1'b0));

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule